// File: doc/BRIEF.md
# Three-Axis Linear Step Interpolator

This block moves three axes along a straight line at the same time. It uses digital differential analysis. A controller loads one signed displacement per axis and pulses `start`. From then on, every cycle in which `rate_en` is high counts as one iteration. In each iteration, every axis adds the magnitude of its displacement into its own n-bit accumulator. An axis emits one step pulse each time its accumulator wraps past 2^n. Each axis also drives a direction level taken from the sign of its displacement.

A move always takes exactly 2^n iterations. Each accumulator starts at zero, so after 2^n iterations an axis has emitted as many pulses as the magnitude of its displacement, and all axes stop on the same iteration. `busy` is high while iterations are running. `done` is high for a single cycle when the move ends. The pace of `rate_en` sets the feed speed: a fast enable gives a dense pulse train, a sparse enable gives a slow one.

Top module: `dda_interp3`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `step`, `dir`, `busy` and `done` are all 0.
- R2: When `start` is high at a clock edge while both `busy` and `done` are low, the move is accepted. `busy` is 1 from the next cycle. Each `dir` bit is set to the sign bit of its axis displacement: 1 when the displacement is negative, 0 otherwise.
- R3: In every accepted iteration (a `rate_en`-high edge while busy), each axis adds its magnitude into an n-bit accumulator that was cleared at acceptance. The axis's `step` bit is 1 for exactly the one cycle after each iteration whose sum carries out of n bits, and 0 in every other cycle.
- R4: For displacements with magnitude at most 2^n-1, each axis emits exactly as many step pulses in a move as the magnitude of its displacement.
- R5: The move ends on the 2^n-th iteration. In the following cycle, `busy` is 0 and `done` is 1, and `done` is 0 again one cycle later. `busy` and `done` are never high together.
- R6: A `start` that arrives while `busy` or `done` is high is ignored. The displacement, the direction and the pulse counts of the running move do not change, and no new move begins.
- R7: Each `dir` bit holds its value from acceptance until the next accepted move.
- R8: All axes stay in the same phase (idle, running, finishing) in every cycle, so they all finish on the same iteration.
- R9: An axis with zero displacement emits no pulses, but the move still lasts 2^n iterations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a move |
| rate_en | input | 1 | Iteration enable; each high cycle is one integration step |
| disp | input | NAX*(ACC_W+1) | Signed two's-complement displacement per axis; axis k at bits [k*(ACC_W+1) +: ACC_W+1] |
| step | output | NAX | One-cycle step pulse per axis |
| dir | output | NAX | Direction per axis, 1 = negative |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move flag |

## Verification
The properties assume that no displacement uses the most negative code. That code has no n-bit magnitude, so the exact pulse count would not hold for it. The stimulus therefore keeps every axis within -15 to 15 for the default 4-bit accumulator. Apart from that, the checks make no assumption about how `rate_en` is paced or about when `start` arrives. The stimulus paces the enable on every cycle, on every third cycle and in an irregular pattern. It also drives `start` in the middle of a move and in the finishing cycle, so the rules for ignoring `start` are exercised at the ports.

// File: rtl/dda_pkg.sv
package dda_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;
endpackage

// File: rtl/dda_ticker.sv
// Shared iteration counter: flags the final iteration of a move.
module dda_ticker #(
    parameter int ACC_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    typedef struct packed {
        logic [ACC_W-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (tick) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last = tick && (r_q.cnt == {ACC_W{1'b1}});
endmodule

// File: rtl/dda_axis.sv
// One integrator: magnitude register, accumulator, carry-out step, phase FSM.
module dda_axis
    import dda_pkg::*;
#(
    parameter int ACC_W = 4,
    localparam int DW   = ACC_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          tick,
    input  logic          last,
    input  logic [DW-1:0] disp,
    output logic          step,
    output logic          dir,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        phase_e           ph;
        logic [ACC_W-1:0] mag;
        logic [ACC_W-1:0] acc;
        logic             dir;
        logic             step;
    } axis_regs_t;

    axis_regs_t r_d, r_q;
    logic [ACC_W:0] sum_v;
    logic [DW-1:0]  neg_v;

    always_comb begin
        r_d      = r_q;
        r_d.step = 1'b0;
        sum_v    = {1'b0, r_q.acc} + {1'b0, r_q.mag};
        neg_v    = ~disp + DW'(1);
        unique case (r_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    r_d.ph  = PH_RUN;
                    r_d.acc = '0;
                    r_d.dir = disp[DW-1];
                    r_d.mag = disp[DW-1] ? neg_v[ACC_W-1:0] : disp[ACC_W-1:0];
                end
            end
            PH_RUN: begin
                if (tick) begin
                    r_d.acc  = sum_v[ACC_W-1:0];
                    r_d.step = sum_v[ACC_W];
                    if (last) r_d.ph = PH_FIN;
                end
            end
            PH_FIN: begin
                r_d.ph = PH_IDLE;
            end
            default: begin
                r_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign step = r_q.step;
    assign dir  = r_q.dir;
    assign busy = (r_q.ph == PH_RUN);
    assign done = (r_q.ph == PH_FIN);
endmodule

// File: rtl/dda_interp3.sv
// Multi-axis linear interpolator top: lockstep integrators sharing one ticker.
module dda_interp3 #(
    parameter int NAX   = 3,
    parameter int ACC_W = 4,
    localparam int DW   = ACC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rate_en,
    input  logic [NAX*DW-1:0] disp,
    output logic [NAX-1:0]    step,
    output logic [NAX-1:0]    dir,
    output logic              busy,
    output logic              done
);
    logic [NAX-1:0] axis_busy;
    logic [NAX-1:0] axis_done;
    logic           launch;
    logic           run_tick;
    logic           last_tick;

    assign launch   = start && !axis_busy[0] && !axis_done[0];
    assign run_tick = rate_en && axis_busy[0];

    dda_ticker #(.ACC_W(ACC_W)) ticker_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .tick  (run_tick),
        .last  (last_tick)
    );

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        dda_axis #(.ACC_W(ACC_W)) axis_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .launch (launch),
            .tick   (run_tick),
            .last   (last_tick),
            .disp   (disp[g*DW +: DW]),
            .step   (step[g]),
            .dir    (dir[g]),
            .busy   (axis_busy[g]),
            .done   (axis_done[g])
        );
    end

    assign busy = axis_busy[0];
    assign done = axis_done[0];
endmodule

// File: rtl/dda_interp3_chk.sv
module dda_interp3_chk #(
    parameter int NAX = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           rate_en,
    input logic [NAX-1:0] step,
    input logic [NAX-1:0] dir,
    input logic           busy,
    input logic           done,
    input logic [NAX-1:0] axis_busy,
    input logic [NAX-1:0] axis_done
);
    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (|step) |-> ($past(rate_en) && $past(busy)));                    // R3
    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);                             // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R5
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));                                           // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                                // R5
    AST_FIN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                                 // R6
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir));                         // R7
    AST_LOCKSTEP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_busy == '0) || (axis_busy == '1));                         // R8
    AST_LOCKSTEP_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_done == '0) || (axis_done == '1));                         // R8
endmodule

bind dda_interp3 dda_interp3_chk #(.NAX(NAX)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rate_en   (rate_en),
    .step      (step),
    .dir       (dir),
    .busy      (busy),
    .done      (done),
    .axis_busy (axis_busy),
    .axis_done (axis_done)
);

// File: tb/dda_interp3_tb_top.sv
`timescale 1ns/1ps
module dda_interp3_tb_top;
    localparam int NAX   = 3;
    localparam int ACC_W = 4;
    localparam int DW    = ACC_W + 1;
    localparam int FULL  = 1 << ACC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              rate_en = 1'b0;
    logic [NAX*DW-1:0] disp = '0;
    logic [NAX-1:0]    step;
    logic [NAX-1:0]    dir;
    logic              busy;
    logic              done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference
    int m_phase = 0;
    int m_cnt = 0;
    int m_acc [NAX];
    int m_mag [NAX];
    bit m_step [NAX];
    bit m_dir [NAX];
    int pc [NAX];

    always #4 clk = ~clk;

    dda_interp3 #(.NAX(NAX), .ACC_W(ACC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_en(rate_en),
        .disp(disp), .step(step), .dir(dir), .busy(busy), .done(done)
    );

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int field(input int ax);
        logic [DW-1:0] f;
        f = disp[ax*DW +: DW];
        return f[DW-1] ? (int'(f) - (1 << DW)) : int'(f);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_cnt = 0;
            for (int a = 0; a < NAX; a++) begin
                m_acc[a] = 0; m_mag[a] = 0; m_step[a] = 0; m_dir[a] = 0;
            end
        end else begin
            for (int a = 0; a < NAX; a++) m_step[a] = 0;
            if (m_phase == 0) begin
                if (start) begin
                    m_phase = 1;
                    m_cnt = 0;
                    for (int a = 0; a < NAX; a++) begin
                        m_acc[a] = 0;
                        m_mag[a] = absv(field(a));
                        m_dir[a] = (field(a) < 0);
                    end
                end
            end else if (m_phase == 1) begin
                if (rate_en) begin
                    m_cnt++;
                    for (int a = 0; a < NAX; a++) begin
                        m_acc[a] += m_mag[a];
                        if (m_acc[a] >= FULL) begin
                            m_acc[a] -= FULL;
                            m_step[a] = 1;
                        end
                    end
                    if (m_cnt == FULL) m_phase = 2;
                end
            end else begin
                m_phase = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        for (int a = 0; a < NAX; a++) begin
            check(step[a] == m_step[a], "R3", $sformatf("step[%0d]", a), step[a], m_step[a]);
            check(dir[a] == m_dir[a], "R7", $sformatf("dir[%0d]", a), dir[a], m_dir[a]);
            if (step[a]) pc[a]++;
        end
        check(busy == (m_phase == 1), "R5", "busy", busy, m_phase == 1);
        check(done == (m_phase == 2), "R5", "done", done, m_phase == 2);
    endtask

    function automatic bit rate_pat(input int mode, input int k);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (k % 3) == 0;
        return ((k * 5) % 7) < 3;
    endfunction

    // ign: 0 none, 1 restart request mid-move, 2 start request in the finishing cycle
    task automatic run_move(input int d0, input int d1, input int d2,
                            input int mode, input int ign);
        int k = 0;
        int exp_v [NAX];
        exp_v[0] = d0; exp_v[1] = d1; exp_v[2] = d2;
        disp = {DW'(d2), DW'(d1), DW'(d0)};
        start = 1'b1;
        rate_en = rate_pat(mode, 0);
        for (int a = 0; a < NAX; a++) pc[a] = 0;
        cyc();
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        for (int a = 0; a < NAX; a++)
            check(dir[a] == (exp_v[a] < 0), "R2", $sformatf("dir[%0d] after accept", a),
                  dir[a], exp_v[a] < 0);
        while (!done && k < 1000) begin
            rate_en = rate_pat(mode, k + 1);
            if (ign == 1 && k == 5) begin
                start = 1'b1;
                disp = {DW'(-d2), DW'(3), DW'(-d0)};
            end else begin
                start = 1'b0;
            end
            cyc();
            k++;
        end
        start = 1'b0;
        for (int a = 0; a < NAX; a++) begin
            if (exp_v[a] == 0)
                check(pc[a] == 0, "R9", $sformatf("pulses axis %0d", a), pc[a], 0);
            else
                check(pc[a] == absv(exp_v[a]), (ign == 1) ? "R6" : "R4",
                      $sformatf("pulses axis %0d", a), pc[a], absv(exp_v[a]));
        end
        if (ign == 2) begin
            start = 1'b1;
            disp = {DW'(5), DW'(-5), DW'(7)};
            rate_en = 1'b1;
            cyc();
            start = 1'b0;
            check(busy == 1'b0, "R6", "busy after start in finishing cycle", busy, 0);
            for (int a = 0; a < NAX; a++)
                check(dir[a] == (exp_v[a] < 0), "R6", $sformatf("dir[%0d] kept", a),
                      dir[a], exp_v[a] < 0);
        end
        rate_en = 1'b0;
        cyc();
    endtask

    task automatic count_ticks(input int d0, input int mode);
        int ticks = 0;
        int k = 0;
        disp = {DW'(0), DW'(0), DW'(d0)};
        start = 1'b1;
        rate_en = 1'b0;
        cyc();
        start = 1'b0;
        while (!done && k < 1000) begin
            rate_en = rate_pat(mode, k);
            if (rate_en && busy) ticks++;
            cyc();
            k++;
        end
        check(ticks == FULL, "R5", "iterations in a move", ticks, FULL);
        rate_en = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (3) begin
            rate_en = 1'b1;
            @(negedge clk);
            check(step == '0 && dir == '0 && !busy && !done, "R1", "outputs in reset",
                  {step, dir, busy, done}, 0);
        end
        rst_n = 1'b1;
        cyc();
        check(step == '0 && dir == '0 && !busy && !done, "R1", "outputs after reset",
              {step, dir, busy, done}, 0);
        repeat (3) cyc();
        rate_en = 1'b0;
        run_move(8, 15, 11, 0, 0);          // R4 main vector
        run_move(-8, 15, -11, 1, 0);        // R4 R2 signed, sparse rate
        run_move(0, -15, 1, 2, 0);          // R9 zero axis, R4 extremes
        run_move(7, -3, 12, 0, 1);          // R6 restart ignored mid-move
        run_move(-6, 9, 0, 1, 2);           // R6 start ignored while finishing
        count_ticks(5, 2);                  // R5 exactly 2^n iterations
        run_move(-15, -15, -15, 0, 0);      // R8 all axes finish together
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule